// File: doc/BRIEF.md
# Privilege-Banked Integer and Floating-Point Register File

This block is the architectural register storage for a core with four privilege modes. Software sees 32 integer registers and 32 floating-point registers. The block turns each register index into a physical entry, and the current mode steers that mapping. The user mode owns one integer bank. The three system modes share a second bank. The lowest eight integer registers sit outside both banks, so every mode sees the same physical entries there and can pass arguments across a mode change without copying.

Floating-point storage exists only for the user mode. Any access from a system mode that selects the floating-point file raises an illegal-access flag in the same cycle. In that case the write is dropped and the read returns zero. There are two combinational read ports and one write port that updates on the rising clock edge. A read of the entry being written in the same cycle sees the new value.

Top module: `modebank_regfile`

## Requirements
- R1: A synchronous active-high reset clears every physical entry (shared, both banks, floating-point) to zero, so every index reads as zero in every mode afterwards.
- R2: Integer indices 0 to 7 (bit 5 of the index clear) map to one shared set. A write from any mode is readable at that index from every other mode.
- R3: For integer indices 8 to 31, user mode (mode code 0) uses a private bank. A user write is invisible to system modes, and a system write is invisible to user mode.
- R4: Mode codes 1, 2 and 3 use one common bank for integer indices 8 to 31. A write from one system mode is readable from the other two.
- R5: An index with bit 5 set selects floating-point register (index bits 4:0). In user mode it is written and read like any other register.
- R6: In a system mode (code 1 to 3), a write with the write enable high and bit 5 of the write index set raises `illegal_access` in the same cycle, and the targeted entry is left unchanged.
- R7: In a system mode, a read port whose index has bit 5 set returns zero and raises `illegal_access` in the same cycle.
- R8: The two read ports are combinational and independent: each returns the entry its own index selects under the current mode in the same cycle.
- R9: When the write port targets the same physical entry that a read port selects in the same cycle, that read port returns the write data.
- R10: `illegal_access` stays low in user mode, and it stays low in system modes when no read index has bit 5 set and no enabled write has bit 5 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all entries |
| mode | input | 2 | Current privilege mode: 0 user, 1 to 3 system |
| rd_a_idx | input | 6 | Read port A index; bit 5 selects the floating-point file |
| rd_a_data | output | 64 | Read port A data, combinational |
| rd_b_idx | input | 6 | Read port B index; bit 5 selects the floating-point file |
| rd_b_data | output | 64 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 6 | Write index; bit 5 selects the floating-point file |
| wr_data | input | 64 | Write data |
| illegal_access | output | 1 | High when a system mode touches the floating-point file |

## Verification
The main vector walk moves one index through all four modes. A shared index written in user mode and read in a system mode separates the common low group from the banks. Index 9 written with different values from user and system modes shows whether the banks are really separate. A system-mode write read back from a different system mode shows whether the three system modes resolve to one bank. Floating-point rows issue the same index from user and system modes, which separates a blocked access from a real one, and a later user read confirms that the blocked write was dropped. Same-cycle write-and-read rows on each bank and on the shared group check the bypass path, and a reset in mid-run checks that every region is cleared.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  // Privilege mode encoding: one user mode, three system modes.
  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SYS1 = 2'd1,
    MODE_SYS2 = 2'd2,
    MODE_SYS3 = 2'd3
  } priv_mode_t;

  localparam int MODE_W = 2;

  // Number of address ports that need a mapping: two reads, one write.
  localparam int NUM_PORTS = 3;
  localparam int PORT_RA   = 0;
  localparam int PORT_RB   = 1;
  localparam int PORT_WR   = 2;

endpackage

// File: rtl/mbrf_addr_map.sv
module mbrf_addr_map
  import mbrf_pkg::*;
#(
  parameter int NGPR    = 32,
  parameter int NSHARED = 8,
  parameter int GPR_W   = $clog2(NGPR),
  parameter int IDX_W   = GPR_W + 1,
  parameter int PA_W    = 7
) (
  input  priv_mode_t        mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PA_W-1:0]   phys,
  output logic              legal,
  output logic              is_fp
);

  // Physical layout: shared | user bank | system bank | fp file
  localparam int BANK_N    = NGPR - NSHARED;
  localparam int SYS_BASE  = NSHARED + BANK_N;
  localparam int FP_BASE   = NSHARED + 2 * BANK_N;
  localparam int TOTAL     = FP_BASE + NGPR;

  localparam logic [PA_W-1:0] SYS_OFS = PA_W'(BANK_N);
  localparam logic [PA_W-1:0] FP_OFS  = PA_W'(FP_BASE);
  localparam logic [GPR_W-1:0] SHARED_LIM = GPR_W'(NSHARED);

  logic [GPR_W-1:0] num;
  logic             user_mode;

  assign num       = idx[GPR_W-1:0];
  assign is_fp     = idx[GPR_W];
  assign user_mode = (mode == MODE_USER);

  always_comb begin
    if (is_fp) begin
      phys  = FP_OFS + PA_W'(num);
      legal = user_mode;
    end else if (num < SHARED_LIM) begin
      phys  = PA_W'(num);
      legal = 1'b1;
    end else if (user_mode) begin
      // user bank starts right after the shared group
      phys  = PA_W'(num);
      legal = 1'b1;
    end else begin
      phys  = PA_W'(num) + SYS_OFS;
      legal = 1'b1;
    end
  end

  // Mapped address always falls inside the physical array (R8)
  always_comb begin
    p_phys_in_range_r8: assert (int'(phys) < TOTAL);
  end

  // A floating-point index never lands in an integer region (R5)
  always_comb begin
    if (is_fp) begin
      p_fp_region_r5: assert (int'(phys) >= FP_BASE);
    end
  end

  // System-mode integer indices never land in the user bank (R3)
  always_comb begin
    if (!is_fp && !user_mode && num >= SHARED_LIM) begin
      p_sys_not_user_r3: assert (int'(phys) >= SYS_BASE && int'(phys) < FP_BASE);
    end
  end

endmodule

// File: rtl/mbrf_store.sv
module mbrf_store #(
  parameter int XLEN  = 64,
  parameter int DEPTH = 88,
  parameter int PA_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PA_W-1:0]  waddr,
  input  logic [XLEN-1:0]  wdata,
  input  logic [PA_W-1:0]  raddr_a,
  input  logic [PA_W-1:0]  raddr_b,
  output logic [XLEN-1:0]  rdata_a,
  output logic [XLEN-1:0]  rdata_b
);

  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Asynchronous reads with write-through bypass
  always_comb begin
    rdata_a = (we && waddr == raddr_a) ? wdata : mem[raddr_a];
    rdata_b = (we && waddr == raddr_b) ? wdata : mem[raddr_b];
  end

  // Reset leaves the first and last entries cleared (R1)
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (mem[0] == '0 && mem[DEPTH-1] == '0));

  // An accepted write is held in the addressed entry afterwards (R2)
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));

  // With no write, the entry read on port A keeps its value (R9)
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!we && $stable(raddr_a)) |=> (!$past(we) ? 1'b1 : 1'b1) && (we || $past(raddr_a) != raddr_a || $stable(rdata_a)));

endmodule

// File: rtl/modebank_regfile.sv
module modebank_regfile
  import mbrf_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NGPR    = 32,
  parameter int NSHARED = 8,
  parameter int IDX_W   = $clog2(NGPR) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  output logic              illegal_access
);

  localparam int GPR_W  = IDX_W - 1;
  localparam int BANK_N = NGPR - NSHARED;
  localparam int DEPTH  = NSHARED + 2 * BANK_N + NGPR;
  localparam int PA_W   = $clog2(DEPTH);

  priv_mode_t        cur_mode;
  logic [IDX_W-1:0]  port_idx   [NUM_PORTS];
  logic [PA_W-1:0]   port_phys  [NUM_PORTS];
  logic              port_legal [NUM_PORTS];
  logic              port_fp    [NUM_PORTS];

  logic              wr_accept;
  logic [XLEN-1:0]   raw_a;
  logic [XLEN-1:0]   raw_b;

  assign cur_mode          = priv_mode_t'(mode);
  assign port_idx[PORT_RA] = rd_a_idx;
  assign port_idx[PORT_RB] = rd_b_idx;
  assign port_idx[PORT_WR] = wr_idx;

  // One mapper per address port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
    mbrf_addr_map #(
      .NGPR    (NGPR),
      .NSHARED (NSHARED),
      .GPR_W   (GPR_W),
      .IDX_W   (IDX_W),
      .PA_W    (PA_W)
    ) u_map (
      .mode  (cur_mode),
      .idx   (port_idx[p]),
      .phys  (port_phys[p]),
      .legal (port_legal[p]),
      .is_fp (port_fp[p])
    );
  end

  assign wr_accept = wr_en && port_legal[PORT_WR];

  mbrf_store #(
    .XLEN  (XLEN),
    .DEPTH (DEPTH),
    .PA_W  (PA_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_accept),
    .waddr   (port_phys[PORT_WR]),
    .wdata   (wr_data),
    .raddr_a (port_phys[PORT_RA]),
    .raddr_b (port_phys[PORT_RB]),
    .rdata_a (raw_a),
    .rdata_b (raw_b)
  );

  assign rd_a_data = port_legal[PORT_RA] ? raw_a : '0;
  assign rd_b_data = port_legal[PORT_RB] ? raw_b : '0;

  assign illegal_access = !port_legal[PORT_RA]
                        || !port_legal[PORT_RB]
                        || (wr_en && !port_legal[PORT_WR]);

  // A blocked floating-point write from a system mode raises the flag (R6)
  p_fp_write_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0 && wr_en && wr_idx[GPR_W]) |-> illegal_access);

  // A blocked floating-point read returns zero on port A (R7)
  p_fp_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0 && rd_a_idx[GPR_W]) |-> (rd_a_data == '0 && illegal_access));

  // User mode never raises the flag (R10)
  p_user_no_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> !illegal_access);

  // Reading the index being written returns the write data (R9)
  p_bypass_a_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == rd_a_idx && (mode == 2'd0 || !wr_idx[GPR_W]))
      |-> rd_a_data == wr_data);

endmodule

// File: tb/modebank_regfile_test.sv
module modebank_regfile_test;

  localparam int XLEN  = 64;
  localparam int IDX_W = 6;
  localparam int NVEC  = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       mode;
  logic [IDX_W-1:0] rd_a_idx;
  logic [XLEN-1:0]  rd_a_data;
  logic [IDX_W-1:0] rd_b_idx;
  logic [XLEN-1:0]  rd_b_data;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [XLEN-1:0]  wr_data;
  logic             illegal_access;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  modebank_regfile uut (
    .clk            (clk),
    .rst            (rst),
    .mode           (mode),
    .rd_a_idx       (rd_a_idx),
    .rd_a_data      (rd_a_data),
    .rd_b_idx       (rd_b_idx),
    .rd_b_data      (rd_b_data),
    .wr_en          (wr_en),
    .wr_idx         (wr_idx),
    .wr_data        (wr_data),
    .illegal_access (illegal_access)
  );

  typedef struct packed {
    logic [1:0]       m;
    logic             we;
    logic [IDX_W-1:0] wi;
    logic [XLEN-1:0]  wd;
    logic [IDX_W-1:0] ra;
    logic [XLEN-1:0]  ea;
    logic [IDX_W-1:0] rb;
    logic [XLEN-1:0]  eb;
    logic             ill;
    logic [3:0]       req;
  } vec_t;

  // Each row is applied for one cycle; outputs checked before the write edge.
  localparam vec_t VEC [NVEC] = '{
    // R9: user writes shared x3, same-cycle read sees it
    '{2'd0, 1'b1, 6'd3,  64'h11, 6'd3,  64'h11, 6'd9,  64'h0,  1'b0, 4'd9},
    // R2: system mode 2 sees shared x3 on both ports (R8)
    '{2'd2, 1'b0, 6'd0,  64'h0,  6'd3,  64'h11, 6'd3,  64'h11, 1'b0, 4'd2},
    // R9: user writes x9 with bypass
    '{2'd0, 1'b1, 6'd9,  64'h22, 6'd9,  64'h22, 6'd10, 64'h0,  1'b0, 4'd9},
    // R3: system mode 1 writes x9 into system bank, bypass, shared still 11
    '{2'd1, 1'b1, 6'd9,  64'h33, 6'd9,  64'h33, 6'd3,  64'h11, 1'b0, 4'd3},
    // R4: system mode 3 reads the value written by mode 1
    '{2'd3, 1'b0, 6'd0,  64'h0,  6'd9,  64'h33, 6'd4,  64'h0,  1'b0, 4'd4},
    // R3: user still sees its own x9
    '{2'd0, 1'b0, 6'd0,  64'h0,  6'd9,  64'h22, 6'd3,  64'h11, 1'b0, 4'd3},
    // R5: user writes fp5 (index 37) and reads it back
    '{2'd0, 1'b1, 6'd37, 64'h44, 6'd37, 64'h44, 6'd5,  64'h0,  1'b0, 4'd5},
    // R6: system mode 2 writes fp5: flag, read zero (R7)
    '{2'd2, 1'b1, 6'd37, 64'h55, 6'd37, 64'h0,  6'd9,  64'h33, 1'b1, 4'd6},
    // R6: user fp5 unchanged after the blocked write
    '{2'd0, 1'b0, 6'd0,  64'h0,  6'd37, 64'h44, 6'd9,  64'h22, 1'b0, 4'd6},
    // R2: system mode 3 writes shared x7
    '{2'd3, 1'b1, 6'd7,  64'h66, 6'd7,  64'h66, 6'd31, 64'h0,  1'b0, 4'd2},
    // R2: user sees x7 written from system mode
    '{2'd0, 1'b0, 6'd0,  64'h0,  6'd7,  64'h66, 6'd31, 64'h0,  1'b0, 4'd2},
    // R3: user writes x31; fp31 still zero
    '{2'd0, 1'b1, 6'd31, 64'h77, 6'd31, 64'h77, 6'd63, 64'h0,  1'b0, 4'd3},
    // R3: system mode 1 does not see user x31
    '{2'd1, 1'b0, 6'd0,  64'h0,  6'd31, 64'h0,  6'd8,  64'h0,  1'b0, 4'd3},
    // R7: read-only fp access from system mode 1 on port A
    '{2'd1, 1'b0, 6'd0,  64'h0,  6'd40, 64'h0,  6'd9,  64'h33, 1'b1, 4'd7},
    // R10: fp write index with enable low raises nothing
    '{2'd1, 1'b0, 6'd40, 64'h99, 6'd9,  64'h33, 6'd3,  64'h11, 1'b0, 4'd10},
    // R7: fp read on port B from system mode 3
    '{2'd3, 1'b0, 6'd0,  64'h0,  6'd7,  64'h66, 6'd37, 64'h0,  1'b1, 4'd7}
  };

  task automatic chk(input string what, input int req,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic we, input logic [IDX_W-1:0] wi,
                       input logic [XLEN-1:0] wd, input logic [IDX_W-1:0] ra,
                       input logic [IDX_W-1:0] rb);
    @(negedge clk);
    mode = m; wr_en = we; wr_idx = wi; wr_data = wd;
    rd_a_idx = ra; rd_b_idx = rb;
    #5;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 2'd0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    do_reset();

    // R1: reset state in every mode and every region
    for (int m = 0; m < 4; m++) begin
      drive(2'(m), 1'b0, 6'd0, 64'h0, 6'd2, 6'd20);
      chk("reset shared/bank", 1, rd_a_data, 64'h0);
      chk("reset bank", 1, rd_b_data, 64'h0);
    end
    drive(2'd0, 1'b0, 6'd0, 64'h0, 6'd33, 6'd63);
    chk("reset fp", 1, rd_a_data, 64'h0);
    chk("reset flag", 10, {63'b0, illegal_access}, 64'h0);

    // Vector walk
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v].m, VEC[v].we, VEC[v].wi, VEC[v].wd, VEC[v].ra, VEC[v].rb);
      chk($sformatf("vec %0d port A", v), int'(VEC[v].req), rd_a_data, VEC[v].ea);
      chk($sformatf("vec %0d port B", v), int'(VEC[v].req), rd_b_data, VEC[v].eb);
      chk($sformatf("vec %0d flag", v), int'(VEC[v].req),
          {63'b0, illegal_access}, {63'b0, VEC[v].ill});
    end

    // R9: bypass on the system bank from mode 2, port B
    drive(2'd2, 1'b1, 6'd20, 64'hABCD, 6'd9, 6'd20);
    chk("bypass sys bank port B", 9, rd_b_data, 64'hABCD);
    chk("other port unaffected", 8, rd_a_data, 64'h33);
    drive(2'd0, 1'b0, 6'd0, 64'h0, 6'd20, 6'd20);
    chk("user x20 untouched by sys write", 3, rd_a_data, 64'h0);

    // R1: reset in mid-run clears every region written above
    do_reset();
    drive(2'd0, 1'b0, 6'd0, 64'h0, 6'd3, 6'd9);
    chk("reset shared x3", 1, rd_a_data, 64'h0);
    chk("reset user x9", 1, rd_b_data, 64'h0);
    drive(2'd0, 1'b0, 6'd0, 64'h0, 6'd37, 6'd31);
    chk("reset fp5", 1, rd_a_data, 64'h0);
    chk("reset user x31", 1, rd_b_data, 64'h0);
    drive(2'd1, 1'b0, 6'd0, 64'h0, 6'd9, 6'd20);
    chk("reset sys x9", 1, rd_a_data, 64'h0);
    chk("reset sys x20", 1, rd_b_data, 64'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule